// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block lets a clocked host read or write single bytes in an external asynchronous static RAM of 2^19 bytes. The RAM is controlled by active-low chip select, write enable and output enable, and it shares one bidirectional data bus with the controller. The host offers one request at a time on a valid/ready channel that carries an address, write data and a write flag. A read returns its byte on a registered data output together with a one-cycle valid strobe.

All RAM timing comes from cycle counts. Each count is the ceiling of a nanosecond limit divided by the clock period. At the default 10 ns clock this gives two access cycles, two write-pulse cycles and one turnaround cycle. During a write, output enable stays high so that the shorter pulse limit applies. Write enable falls before chip select, which keeps the RAM from driving the bus. After a read, the controller waits through a turnaround gap before it drives the bus again.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is low and right after it is released, sram_cs_n_o, sram_we_n_o and sram_oe_n_o are 1, sram_dq_oe_o is 0, rsp_valid_o is 0, and req_ready_o is 1 once reset is released.
- R2: req_ready_o is high only while the controller is idle. While it is high, all three strobes are high and the data driver is off. A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. req_write_i=1 selects a write and req_write_i=0 selects a read.
- R3: A read holds chip select and output enable low and write enable high for RD_CYC cycles, where RD_CYC is ceil(15 ns / clock period), which is 2 at the defaults. The bus is sampled on the edge that ends those cycles. rsp_valid_o is then high for exactly one cycle, the (RD_CYC+1)-th cycle after acceptance.
- R4: After a read, chip select and output enable go high together. The controller stays busy for one capture cycle plus TA_CYC turnaround cycles, where TA_CYC is ceil(7 ns / clock period), so req_ready_o returns in cycle RD_CYC+2+TA_CYC after acceptance.
- R5: A write runs as one setup cycle (write enable low, chip select high, data driven), then WP_CYC cycles with both low, where WP_CYC is ceil(12 ns / clock period), then one recovery cycle with both high and data still driven. req_ready_o returns in cycle WP_CYC+3.
- R6: Output enable is high in every cycle in which write enable is low.
- R7: Chip select never falls while write enable is low unless write enable was already low in the cycle before.
- R8: sram_addr_o is constant over every busy cycle of a transaction. sram_dq_o is constant and equal to the write byte while the driver is enabled.
- R9: The data driver is never enabled while output enable is low, nor in the cycle after output enable rises.
- R10: A read of any address from 0 to 19'h7FFFF returns the byte most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, request accepted this edge |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write byte |
| rsp_valid_o | output | 1 | Read data strobe, one cycle |
| rsp_rdata_o | output | DATA_W | Read byte |
| sram_addr_o | output | ADDR_W | RAM address |
| sram_cs_n_o | output | 1 | RAM chip select, active low |
| sram_we_n_o | output | 1 | RAM write enable, active low |
| sram_oe_n_o | output | 1 | RAM output enable, active low |
| sram_dq_o | output | DATA_W | Data driven toward RAM |
| sram_dq_i | input | DATA_W | Data received from RAM |
| sram_dq_oe_o | output | 1 | Enable of the controller's data driver |

## Verification
The following pin relations are checked on every cycle: output enable stays high during write enable, write enable leads chip select, the driver stays off around output enable, the address and data hold still while busy, the response strobe is a single pulse, and the write pulse is long enough. Other properties need an attached RAM model and can only be shown by the bench scenarios: that sampling waits until the access time has elapsed, that the data actually stored is correct, that each transaction lasts the expected number of cycles, and that read-back works at the address extremes and after overwrites.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACC, ST_RD_CAP, ST_TURN, ST_WR_SETUP, ST_WR_PULSE, ST_WR_REC
  } state_e;

  localparam int DEF_CLK_PS   = 10000;
  localparam int DEF_T_AA_PS  = 15000;
  localparam int DEF_T_WP_PS  = 12000;
  localparam int DEF_T_OHZ_PS = 7000;

  function automatic int cycles_for(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/sram_ctrl_cnt.sv
module sram_ctrl_cnt #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 2,
  parameter int TA_CYC = 1,
  parameter int CNT_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cnt_dec_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             cs_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             drv_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    cnt_dec_o  = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (req_write_i) state_d = ST_WR_SETUP;
        else begin
          state_d    = ST_RD_ACC;
          cnt_load_o = 1'b1;
          cnt_val_o  = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD_ACC: if (cnt_zero_i) begin
        state_d   = ST_RD_CAP;
        capture_o = 1'b1;
      end else cnt_dec_o = 1'b1;
      ST_RD_CAP: begin
        state_d    = ST_TURN;
        cnt_load_o = 1'b1;
        cnt_val_o  = CNT_W'(TA_CYC - 1);
      end
      ST_TURN: if (cnt_zero_i) state_d = ST_IDLE;
               else cnt_dec_o = 1'b1;
      ST_WR_SETUP: begin
        state_d    = ST_WR_PULSE;
        cnt_load_o = 1'b1;
        cnt_val_o  = CNT_W'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (cnt_zero_i) state_d = ST_WR_REC;
                   else cnt_dec_o = 1'b1;
      ST_WR_REC: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state so the pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      drv_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_o  <= !(state_d inside {ST_RD_ACC, ST_WR_PULSE});
      we_n_o  <= !(state_d inside {ST_WR_SETUP, ST_WR_PULSE});
      oe_n_o  <= (state_d != ST_RD_ACC);
      drv_o   <= (state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_REC});
    end
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;
endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      wdata_o  <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
      end
      if (capture_i) rdata_o <= mem_rdata_i;
      rvalid_o <= capture_i;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = DEF_CLK_PS,
  parameter int T_AA_PS  = DEF_T_AA_PS,
  parameter int T_WP_PS  = DEF_T_WP_PS,
  parameter int T_OHZ_PS = DEF_T_OHZ_PS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_n_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);
  localparam int RD_CYC  = cycles_for(T_AA_PS, CLK_PS);
  localparam int WP_CYC  = cycles_for(T_WP_PS, CLK_PS);
  localparam int TA_CYC  = cycles_for(T_OHZ_PS, CLK_PS);
  localparam int MAX_CYC = (RD_CYC > WP_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                             : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC);
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             cnt_load, cnt_dec, cnt_zero, accept, capture;
  logic [CNT_W-1:0] cnt_val;

  sram_ctrl_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(cnt_load), .load_val_i(cnt_val), .dec_i(cnt_dec), .zero_o(cnt_zero)
  );

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i,
    .cnt_zero_i(cnt_zero), .cnt_load_o(cnt_load), .cnt_val_o(cnt_val), .cnt_dec_o(cnt_dec),
    .ready_o(req_ready_o), .accept_o(accept), .capture_o(capture),
    .cs_n_o(sram_cs_n_o), .we_n_o(sram_we_n_o), .oe_n_o(sram_oe_n_o), .drv_o(sram_dq_oe_o)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i, .rst_ni,
    .accept_i(accept), .capture_i(capture),
    .req_addr_i, .req_wdata_i, .mem_rdata_i(sram_dq_i),
    .addr_o(sram_addr_o), .wdata_o(sram_dq_o),
    .rdata_o(rsp_rdata_o), .rvalid_o(rsp_valid_o)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_cs_n_o,
  input logic              sram_we_n_o,
  input logic              sram_oe_n_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o
);
  localparam int         WP_CYC = cycles_for(DEF_T_WP_PS, DEF_CLK_PS);
  localparam logic [7:0] WP_MIN = 8'(WP_CYC);

  logic       wr_act;
  logic [7:0] wr_run;
  assign wr_act = !sram_cs_n_o && !sram_we_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         wr_run <= '0;
    else if (wr_act && wr_run != 8'hFF)  wr_run <= wr_run + 8'd1;
    else if (!wr_act)                    wr_run <= '0;
  end

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_cs_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o));

  p_rsp_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_pulse_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_run != 8'd0 && !wr_act) |-> (wr_run >= WP_MIN));

  p_oe_off_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> sram_oe_n_o);

  p_we_leads_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sram_cs_n_o) && !sram_we_n_o) |-> $past(!sram_we_n_o));

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(sram_addr_o));

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  p_drv_no_oe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o);

  p_drv_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> $past(sram_oe_n_o));
endmodule

bind sram_ctrl sram_ctrl_chk u_chk (
  .clk_i, .rst_ni, .req_ready_o, .rsp_valid_o, .sram_addr_o,
  .sram_cs_n_o, .sram_we_n_o, .sram_oe_n_o, .sram_dq_o, .sram_dq_oe_o
);

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int RD_CYC = (15 + CLK_NS - 1) / CLK_NS;
  localparam int WP_CYC = (12 + CLK_NS - 1) / CLK_NS;
  localparam int TA_CYC = (7 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [7:0]  rsp_rdata_o;
  logic [18:0] sram_addr_o;
  logic        sram_cs_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i = '0;

  int total = 0, bad = 0;
  logic [7:0] ram_mem [logic [18:0]];
  logic [7:0] ref_mem [logic [18:0]];

  always #(CLK_NS / 2) clk = ~clk;

  sram_ctrl dut_i (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_ready_o, .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o, .rsp_rdata_o,
    .sram_addr_o, .sram_cs_n_o, .sram_we_n_o, .sram_oe_n_o, .sram_dq_o, .sram_dq_i,
    .sram_dq_oe_o
  );

  function automatic logic [7:0] peek(input logic [7:0] m [logic [18:0]], input logic [18:0] a);
    return m.exists(a) ? m[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // RAM model: data valid only once the access time has elapsed
  logic [20:0] prev_key = '1;
  int  age = 0, wr_len = 0, contention = 0;
  bit  drv_prev = 1'b0, wr_oe_bad = 1'b0, wr_drv_bad = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;

  always @(negedge clk) begin
    logic [20:0] key;
    bit ram_drv, act;
    key = {sram_addr_o, sram_cs_n_o, sram_oe_n_o};
    if (key != prev_key) age = 1; else if (age < 1000) age++;
    prev_key = key;
    ram_drv = !sram_cs_n_o && sram_we_n_o && !sram_oe_n_o;
    if (ram_drv) sram_dq_i = (age >= RD_CYC) ? peek(ram_mem, sram_addr_o)
                                             : ~peek(ram_mem, sram_addr_o);
    else         sram_dq_i = sram_dq_oe_o ? sram_dq_o : 8'h5A;
    if (sram_dq_oe_o && (ram_drv || drv_prev)) contention++;
    drv_prev = ram_drv;
    act = !sram_cs_n_o && !sram_we_n_o;
    if (act) begin
      wr_len++;
      wr_addr = sram_addr_o;
      wr_data = sram_dq_o;
      if (!sram_oe_n_o) wr_oe_bad = 1'b1;
      if (!sram_dq_oe_o) wr_drv_bad = 1'b1;
    end else if (wr_len != 0) begin
      ram_mem[wr_addr] = wr_data;
      chk(wr_len >= WP_CYC, "R5 write pulse cycles", wr_len, WP_CYC);
      chk(!wr_oe_bad && !wr_drv_bad, "R6 oe high and data driven during pulse",
          {wr_oe_bad, wr_drv_bad}, 0);
      wr_len = 0; wr_oe_bad = 1'b0; wr_drv_bad = 1'b0;
    end
  end

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int j;
    bit hold_ok;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    j = 1; hold_ok = 1'b1;
    while (!req_ready_o && j < 50) begin
      if (sram_addr_o !== a || (sram_dq_oe_o && sram_dq_o !== d)) hold_ok = 1'b0;
      @(negedge clk);
      j++;
    end
    chk(hold_ok, "R8 address/data held during write", sram_addr_o, a);
    chk(j == WP_CYC + 3, "R5 write busy length", j, WP_CYC + 3);
    ref_mem[a] = d;
  endtask

  task automatic do_read(input logic [18:0] a);
    int j, nv, vj;
    bit hold_ok;
    logic [7:0] vd, exp;
    exp = peek(ref_mem, a);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    j = 1; nv = 0; vj = 0; vd = '0; hold_ok = 1'b1;
    while (!req_ready_o && j < 50) begin
      if (sram_addr_o !== a) hold_ok = 1'b0;
      if (rsp_valid_o) begin nv++; vj = j; vd = rsp_rdata_o; end
      @(negedge clk);
      j++;
    end
    if (rsp_valid_o) nv++;
    chk(hold_ok, "R8 address held during read", sram_addr_o, a);
    chk(vj == RD_CYC + 1, "R3 response cycle", vj, RD_CYC + 1);
    chk(nv == 1, "R3 single response pulse", nv, 1);
    chk(vd === exp, "R10 read data", vd, exp);
    chk(j == RD_CYC + 2 + TA_CYC, "R4 read busy length", j, RD_CYC + 2 + TA_CYC);
  endtask

  initial begin : watchdog
    #(CLK_NS * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [18:0] pool [16];
    repeat (3) @(negedge clk);
    chk(sram_cs_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o && !rsp_valid_o,
        "R1 strobes in reset",
        {sram_cs_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o, rsp_valid_o}, 5'b11100);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o && sram_cs_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o,
        "R1 idle after reset", {req_ready_o, sram_cs_n_o, sram_dq_oe_o}, 3'b110);
    chk(!rsp_valid_o, "R1 no response after reset", rsp_valid_o, 0);

    // boundary addresses and data
    do_write(19'h00000, 8'h00);
    do_write(19'h7FFFF, 8'hFF);
    do_read(19'h7FFFF);
    do_read(19'h00000);
    do_read(19'h12345);           // never written: R10 expects 00
    do_write(19'h00005, 8'h3C);
    do_write(19'h00005, 8'hC3);   // overwrite: last write wins
    do_read(19'h00005);
    do_read(19'h00005);           // read after read

    void'($urandom(32'd2024));
    pool[0] = 19'h00000;
    pool[1] = 19'h7FFFF;
    for (int i = 2; i < 16; i++) pool[i] = 19'($urandom);
    for (int n = 0; n < 400; n++) begin
      logic [18:0] a;
      a = pool[$urandom % 16];
      if ($urandom % 2) do_write(a, 8'($urandom));
      else              do_read(a);
    end

    repeat (3) @(negedge clk);
    chk(contention == 0, "R9 bus contention events", contention, 0);
    chk(req_ready_o && sram_cs_n_o && !sram_dq_oe_o, "R2 idle strobes at end",
        {req_ready_o, sram_cs_n_o, sram_dq_oe_o}, 3'b110);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule